// File: doc/BRIEF.md
# Inter-Processor Software Interrupt Dispatcher

This block raises software-generated interrupts (sixteen IDs, 0 to 15) from one processor to others and remembers, for every interrupt ID and every receiving processor, which processors sent it. A processor raises such an interrupt with one 32-bit write to a trigger word. The word holds the interrupt ID, a target-selection filter and an explicit list of target processors. The bus also carries the number of the processor that makes the write. That processor's bit is then set in the source bitmap of every selected target.

A receiving processor takes an interrupt with an acknowledge strobe that carries its own number and the interrupt ID. The block answers one cycle later. The answer holds the ID and the lowest-numbered sender still recorded, and that sender's bit is removed. One sender is therefore returned per acknowledge. The per-processor pending output stays high until every sender has been consumed.

Two banks of byte-wide registers give direct access to the source bitmaps of the accessing processor. One bank clears bits and the other sets them. A read of either bank returns the bitmap. Priority arbitration between interrupts is done elsewhere.

Top module: `sgi_dispatch`

## Requirements
- R1: After synchronous reset every source bitmap is empty, every `sgi_pend` bit is 0 and `ack_rsp_valid` is 0.
- R2: A write with `wr_word`=1 to address 0xF00 and an ID in bits 9:0 below 16 triggers that ID. The target filter in bits 25:24 selects the targets: 0 = the processors flagged in bits 23:16, 1 = every processor except the writer, 2 = the writer alone, 3 = every processor. Target-list bits for processors that are not implemented are dropped. For every selected target, the writer's bit is set in that target's bitmap for the ID, and the change is visible after the next clock edge.
- R3: A trigger write does nothing in three cases: it is a byte access to 0xF00, its ID is 16 or more, or its filter selects no implemented processor.
- R4: `sgi_pend[t*16+n]` is 1 exactly when the source bitmap of ID n for target t is non-empty.
- R5: An acknowledge strobe (`ack_req`) is answered in the next cycle with a one-cycle `ack_rsp_valid` pulse. If the bitmap is not empty, `ack_rsp` carries the ID in bits 9:0, zeros in bits 9:4, and the lowest set source number in bits 12:10, and that source bit is cleared.
- R6: An acknowledge of an ID whose bitmap is empty for the requesting processor returns 1023 and leaves all state unchanged.
- R7: Successive acknowledges of the same ID by the same processor return the recorded sources in ascending order. Pending stays high until the last source has been returned.
- R8: Address 0xF10+n (n = 0..15) clears source bits of ID n for the writing processor: the bits set in the written byte are removed. An aligned word write at 0xF10+4k applies its byte lane j to ID 4k+j.
- R9: Address 0xF20+n sets the written byte's bits in the writing processor's bitmap for ID n, with the same word-lane rule as R8. Bits for processors that are not implemented are ignored.
- R10: `rd_data` shows, in the same cycle, the bitmap of ID `rd_addr[3:0]` for processor `rd_cpu` when `rd_addr` lies in 0xF10..0xF2F, and 0 for any other address.
- R11: Writes to the general pending set/clear bytes of the software interrupt IDs (0x200, 0x201, 0x280, 0x281), of either size, change no source bitmap and no pending bit.
- R12: When a set-bits write and an acknowledge hit the same bitmap in one cycle, the set wins: a source bit that is both set and consumed stays recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_word | input | 1 | 1 = 32-bit write, 0 = byte write (data in bits 7:0) |
| wr_addr | input | 12 | Byte address of the write |
| wr_data | input | 32 | Write data |
| wr_cpu | input | CPU_W | Number of the writing processor |
| rd_addr | input | 12 | Byte address of the bitmap read |
| rd_cpu | input | CPU_W | Processor whose bitmap is read |
| rd_data | output | 8 | Bitmap read data |
| ack_req | input | 1 | Acknowledge strobe |
| ack_cpu | input | CPU_W | Acknowledging processor |
| ack_id | input | 4 | Interrupt ID acknowledged |
| ack_rsp_valid | output | 1 | Acknowledge answer valid |
| ack_rsp | output | 13 | Source in 12:10, ID in 9:0, or 1023 |
| sgi_pend | output | NUM_CPU*16 | Pending bit per processor and ID |

## Verification
Each kind of result arrives on its own schedule. Source bitmaps and `sgi_pend` change at the clock edge that samples the write or the acknowledge. The acknowledge answer sits in a register, so it appears one cycle after the strobe. The bitmap read is combinational. The bench drives every input at a falling edge and checks the acknowledge answer at the next falling edge, which is the first point after the registering edge. It reads the whole bitmap array through the read port only while the bus is idle, so each sample lands at least half a cycle after the last state change.

// File: rtl/sgi_pkg.sv
package sgi_pkg;

    localparam int SGI_COUNT = 16;
    localparam int SGI_W     = 4;
    localparam int IRQ_ID_W  = 10;
    localparam int RSP_W     = 13;

    localparam logic [11:0] TRIG_ADDR    = 12'hF00;
    localparam logic [11:0] SRC_CLR_BASE = 12'hF10;
    localparam logic [11:0] SRC_SET_BASE = 12'hF20;

    localparam logic [IRQ_ID_W-1:0] SPURIOUS_ID = 10'd1023;

    // Target selection carried in bits 25:24 of the trigger word
    typedef enum logic [1:0] {
        TGT_LISTED = 2'd0,
        TGT_OTHERS = 2'd1,
        TGT_SELF   = 2'd2,
        TGT_EVERY  = 2'd3
    } tgt_filter_e;

    // Acknowledge answer: sender number above the interrupt ID
    typedef struct packed {
        logic [2:0]          src;
        logic [IRQ_ID_W-1:0] id;
    } ack_word_t;

    // One byte-lane operation on a bitmap bank
    typedef struct packed {
        logic       set_en;
        logic       clr_en;
        logic [7:0] val;
    } byte_op_t;

    function automatic logic target_hit(input tgt_filter_e f,
                                        input logic listed,
                                        input logic is_self);
        logic r;
        case (f)
            TGT_LISTED: r = listed;
            TGT_OTHERS: r = ~is_self;
            TGT_SELF:   r = is_self;
            default:    r = 1'b1;
        endcase
        return r;
    endfunction

    function automatic logic [2:0] lowest_bit(input logic [7:0] v);
        logic [2:0] r;
        r = 3'd0;
        for (int i = 7; i >= 0; i--) begin
            if (v[i]) r = 3'(i);
        end
        return r;
    endfunction

endpackage

// File: rtl/sgi_trigger_decode.sv
module sgi_trigger_decode
    import sgi_pkg::*;
#(
    parameter  int NUM_CPU = 4,
    localparam int CPU_W   = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
    input  logic                wr_en,
    input  logic                wr_word,
    input  logic [11:0]         wr_addr,
    input  logic [IRQ_ID_W-1:0] trig_id,
    input  tgt_filter_e         trig_filter,
    input  logic [NUM_CPU-1:0]  trig_list,
    input  logic [CPU_W-1:0]    wr_cpu,
    output logic                trig_fire,
    output logic [SGI_W-1:0]    trig_sgi,
    output logic [NUM_CPU-1:0]  trig_tgts
);

    logic addr_hit;
    logic id_ok;

    for (genvar t = 0; t < NUM_CPU; t++) begin : g_tgt
        always_comb begin
            trig_tgts[t] = target_hit(trig_filter, trig_list[t],
                                      wr_cpu == CPU_W'(t));
        end
    end

    always_comb begin
        addr_hit  = wr_en && wr_word && (wr_addr == TRIG_ADDR);
        id_ok     = (trig_id[IRQ_ID_W-1:SGI_W] == '0);
        trig_sgi  = trig_id[SGI_W-1:0];
        trig_fire = addr_hit && id_ok && (|trig_tgts);
    end

endmodule

// File: rtl/sgi_src_cell.sv
module sgi_src_cell
    import sgi_pkg::*;
#(
    parameter  int NUM_CPU = 4,
    localparam int CPU_W   = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
    localparam int MAP_W   = NUM_CPU * NUM_CPU
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               trig_hit,
    input  logic [NUM_CPU-1:0] trig_tgts,
    input  logic [CPU_W-1:0]   wr_cpu,
    input  byte_op_t           lane_op,
    input  logic               ack_hit,
    input  logic [CPU_W-1:0]   ack_cpu,
    input  logic [NUM_CPU-1:0] ack_clr,
    output logic [MAP_W-1:0]   src_map
);

    logic [NUM_CPU-1:0] writer_bit;
    logic [NUM_CPU-1:0] lane_bits;

    assign writer_bit = NUM_CPU'(1) << wr_cpu;
    assign lane_bits  = lane_op.val[NUM_CPU-1:0];

    if (NUM_CPU < 8) begin : g_drop_hi
        logic unused_lane_hi;
        assign unused_lane_hi = ^lane_op.val[7:NUM_CPU];
    end

    for (genvar t = 0; t < NUM_CPU; t++) begin : g_tgt
        logic [NUM_CPU-1:0] map_q;
        logic [NUM_CPU-1:0] set_bits;
        logic [NUM_CPU-1:0] clr_bits;
        logic               own;

        always_comb begin
            own      = (wr_cpu == CPU_W'(t));
            set_bits = '0;
            clr_bits = '0;
            if (trig_hit && trig_tgts[t]) set_bits = set_bits | writer_bit;
            if (lane_op.set_en && own)    set_bits = set_bits | lane_bits;
            if (lane_op.clr_en && own)    clr_bits = clr_bits | lane_bits;
            if (ack_hit && (ack_cpu == CPU_W'(t))) clr_bits = clr_bits | ack_clr;
        end

        // clears first, then sets: a set in the same cycle wins
        always_ff @(posedge clk) begin
            if (rst) begin
                map_q <= '0;
            end else begin
                map_q <= (map_q & ~clr_bits) | set_bits;
            end
        end

        assign src_map[t*NUM_CPU +: NUM_CPU] = map_q;
    end

endmodule

// File: rtl/sgi_ack_unit.sv
module sgi_ack_unit
    import sgi_pkg::*;
#(
    parameter  int NUM_CPU = 4,
    localparam int CPU_W   = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
    localparam int MAP_ALL = SGI_COUNT * NUM_CPU * NUM_CPU
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ack_req,
    input  logic [CPU_W-1:0]   ack_cpu,
    input  logic [SGI_W-1:0]   ack_id,
    input  logic [MAP_ALL-1:0] src_map,
    output logic               ack_take,
    output logic [NUM_CPU-1:0] ack_clr,
    output logic               ack_rsp_valid,
    output logic [RSP_W-1:0]   ack_rsp
);

    logic [NUM_CPU-1:0] sel_map;
    logic [2:0]         src_idx;
    ack_word_t          rsp_d;
    ack_word_t          rsp_q;

    always_comb begin
        sel_map  = src_map[(int'(ack_id) * NUM_CPU + int'(ack_cpu)) * NUM_CPU +: NUM_CPU];
        src_idx  = lowest_bit(8'(sel_map));
        ack_take = ack_req && (|sel_map);
        ack_clr  = ack_take ? (NUM_CPU'(1) << src_idx) : '0;
        if (ack_take) begin
            rsp_d.src = src_idx;
            rsp_d.id  = IRQ_ID_W'(ack_id);
        end else begin
            rsp_d.src = 3'd0;
            rsp_d.id  = SPURIOUS_ID;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ack_rsp_valid <= 1'b0;
            rsp_q         <= '0;
        end else begin
            ack_rsp_valid <= ack_req;
            if (ack_req) rsp_q <= rsp_d;
        end
    end

    assign ack_rsp = rsp_q;

endmodule

// File: rtl/sgi_dispatch.sv
module sgi_dispatch
    import sgi_pkg::*;
#(
    parameter  int NUM_CPU = 4,
    localparam int CPU_W   = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr_en,
    input  logic                         wr_word,
    input  logic [11:0]                  wr_addr,
    input  logic [31:0]                  wr_data,
    input  logic [CPU_W-1:0]             wr_cpu,
    input  logic [11:0]                  rd_addr,
    input  logic [CPU_W-1:0]             rd_cpu,
    output logic [7:0]                   rd_data,
    input  logic                         ack_req,
    input  logic [CPU_W-1:0]             ack_cpu,
    input  logic [SGI_W-1:0]             ack_id,
    output logic                         ack_rsp_valid,
    output logic [RSP_W-1:0]             ack_rsp,
    output logic [NUM_CPU*SGI_COUNT-1:0] sgi_pend
);

    localparam int MAP_W   = NUM_CPU * NUM_CPU;
    localparam int MAP_ALL = SGI_COUNT * MAP_W;

    logic [MAP_ALL-1:0] src_map;
    logic               trig_fire;
    logic [SGI_W-1:0]   trig_sgi;
    logic [NUM_CPU-1:0] trig_tgts;
    logic               ack_take;
    logic [NUM_CPU-1:0] ack_clr;

    sgi_trigger_decode #(.NUM_CPU(NUM_CPU)) u_trig (
        .wr_en       (wr_en),
        .wr_word     (wr_word),
        .wr_addr     (wr_addr),
        .trig_id     (wr_data[IRQ_ID_W-1:0]),
        .trig_filter (tgt_filter_e'(wr_data[25:24])),
        .trig_list   (wr_data[16 +: NUM_CPU]),
        .wr_cpu      (wr_cpu),
        .trig_fire   (trig_fire),
        .trig_sgi    (trig_sgi),
        .trig_tgts   (trig_tgts)
    );

    sgi_ack_unit #(.NUM_CPU(NUM_CPU)) u_ack (
        .clk           (clk),
        .rst           (rst),
        .ack_req       (ack_req),
        .ack_cpu       (ack_cpu),
        .ack_id        (ack_id),
        .src_map       (src_map),
        .ack_take      (ack_take),
        .ack_clr       (ack_clr),
        .ack_rsp_valid (ack_rsp_valid),
        .ack_rsp       (ack_rsp)
    );

    for (genvar n = 0; n < SGI_COUNT; n++) begin : g_sgi
        localparam logic [11:0] CLR_A = SRC_CLR_BASE + 12'(n);
        localparam logic [11:0] SET_A = SRC_SET_BASE + 12'(n);
        localparam int          LANE  = n % 4;

        byte_op_t lane_op;
        logic     clr_sel;
        logic     set_sel;

        always_comb begin
            if (wr_word) begin
                clr_sel = (wr_addr[11:2] == CLR_A[11:2]) && (wr_addr[1:0] == 2'b00);
                set_sel = (wr_addr[11:2] == SET_A[11:2]) && (wr_addr[1:0] == 2'b00);
                lane_op.val = wr_data[8*LANE +: 8];
            end else begin
                clr_sel = (wr_addr == CLR_A);
                set_sel = (wr_addr == SET_A);
                lane_op.val = wr_data[7:0];
            end
            lane_op.clr_en = wr_en && clr_sel;
            lane_op.set_en = wr_en && set_sel;
        end

        sgi_src_cell #(.NUM_CPU(NUM_CPU)) u_cell (
            .clk       (clk),
            .rst       (rst),
            .trig_hit  (trig_fire && (trig_sgi == SGI_W'(n))),
            .trig_tgts (trig_tgts),
            .wr_cpu    (wr_cpu),
            .lane_op   (lane_op),
            .ack_hit   (ack_take && (ack_id == SGI_W'(n))),
            .ack_cpu   (ack_cpu),
            .ack_clr   (ack_clr),
            .src_map   (src_map[n*MAP_W +: MAP_W])
        );

        for (genvar t = 0; t < NUM_CPU; t++) begin : g_pend
            assign sgi_pend[t*SGI_COUNT + n] = |src_map[n*MAP_W + t*NUM_CPU +: NUM_CPU];
        end
    end

    logic             rd_hit;
    logic [SGI_W-1:0] rd_sgi;

    always_comb begin
        rd_sgi = rd_addr[SGI_W-1:0];
        rd_hit = (rd_addr[11:4] == SRC_CLR_BASE[11:4]) ||
                 (rd_addr[11:4] == SRC_SET_BASE[11:4]);
        rd_data = '0;
        if (rd_hit) begin
            rd_data = 8'(src_map[(int'(rd_sgi) * NUM_CPU + int'(rd_cpu)) * NUM_CPU +: NUM_CPU]);
        end
    end

endmodule

// File: rtl/sgi_dispatch_chk.sv
module sgi_dispatch_chk
    import sgi_pkg::*;
#(
    parameter  int NUM_CPU = 4,
    localparam int CPU_W   = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
    input logic                         clk,
    input logic                         rst,
    input logic                         wr_en,
    input logic                         wr_word,
    input logic [11:0]                  wr_addr,
    input logic [31:0]                  wr_data,
    input logic [CPU_W-1:0]             wr_cpu,
    input logic                         ack_req,
    input logic [SGI_W-1:0]             ack_id,
    input logic                         ack_rsp_valid,
    input logic [RSP_W-1:0]             ack_rsp,
    input logic [NUM_CPU*SGI_COUNT-1:0] sgi_pend
);

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (sgi_pend == '0) && !ack_rsp_valid);

    // R5
    ack_answered_chk: assert property (@(posedge clk) disable iff (rst)
        ack_req |=> ack_rsp_valid);

    // R5
    no_ack_no_answer_chk: assert property (@(posedge clk) disable iff (rst)
        !ack_req |=> !ack_rsp_valid);

    // R5
    ack_word_shape_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_rsp_valid && ack_rsp[IRQ_ID_W-1:0] != SPURIOUS_ID) |->
            (ack_rsp[IRQ_ID_W-1:SGI_W] == '0) && (int'(ack_rsp[12:10]) < NUM_CPU)
            && (ack_rsp[SGI_W-1:0] == $past(ack_id)));

    // R6
    empty_ack_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_rsp_valid && ack_rsp[IRQ_ID_W-1:0] == SPURIOUS_ID
         && !$past(wr_en) && !$past(rst)) |-> $stable(sgi_pend));

    // R2
    self_trigger_pends_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_word && wr_addr == TRIG_ADDR && wr_data[25:24] == 2'd2
         && wr_data[9:4] == '0 && !ack_req)
        |=> sgi_pend[int'($past(wr_cpu)) * SGI_COUNT + int'($past(wr_data[3:0]))]);

    // R3
    byte_trigger_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_word && wr_addr == TRIG_ADDR && !ack_req) |=> $stable(sgi_pend));

    // R11
    generic_pend_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !ack_req && (wr_addr == 12'h200 || wr_addr == 12'h201 ||
                               wr_addr == 12'h280 || wr_addr == 12'h281))
        |=> $stable(sgi_pend));

endmodule

bind sgi_dispatch sgi_dispatch_chk #(.NUM_CPU(NUM_CPU)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .wr_en         (wr_en),
    .wr_word       (wr_word),
    .wr_addr       (wr_addr),
    .wr_data       (wr_data),
    .wr_cpu        (wr_cpu),
    .ack_req       (ack_req),
    .ack_id        (ack_id),
    .ack_rsp_valid (ack_rsp_valid),
    .ack_rsp       (ack_rsp),
    .sgi_pend      (sgi_pend)
);

// File: tb/sgi_dispatch_test.sv
module sgi_dispatch_test;
    import sgi_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NC = 4;
    localparam int CW = 2;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_en = 1'b0;
    logic              wr_word = 1'b0;
    logic [11:0]       wr_addr = '0;
    logic [31:0]       wr_data = '0;
    logic [CW-1:0]     wr_cpu = '0;
    logic [11:0]       rd_addr = '0;
    logic [CW-1:0]     rd_cpu = '0;
    logic [7:0]        rd_data;
    logic              ack_req = 1'b0;
    logic [CW-1:0]     ack_cpu = '0;
    logic [3:0]        ack_id = '0;
    logic              ack_rsp_valid;
    logic [12:0]       ack_rsp;
    logic [NC*16-1:0]  sgi_pend;

    int n_checks = 0;
    int n_fail = 0;
    logic [NC-1:0] model [16][NC];

    always #(CLK_PERIOD/2) clk = ~clk;

    sgi_dispatch #(.NUM_CPU(NC)) uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_word(wr_word),
        .wr_addr(wr_addr), .wr_data(wr_data), .wr_cpu(wr_cpu),
        .rd_addr(rd_addr), .rd_cpu(rd_cpu), .rd_data(rd_data),
        .ack_req(ack_req), .ack_cpu(ack_cpu), .ack_id(ack_id),
        .ack_rsp_valid(ack_rsp_valid), .ack_rsp(ack_rsp), .sgi_pend(sgi_pend)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    function automatic int low_src(input logic [NC-1:0] m);
        for (int i = 0; i < NC; i++) if (m[i]) return i;
        return -1;
    endfunction

    // expected effect of a write, computed from R2, R3, R8, R9
    task automatic model_write(input logic word, input logic [11:0] a,
                               input logic [31:0] d, input int cpu);
        if (word && a == 12'hF00 && d[9:4] == 6'd0) begin
            for (int t = 0; t < NC; t++) begin
                int f;
                logic hit;
                f = int'(d[25:24]);
                hit = (f == 0) ? d[16+t] : (f == 1) ? (t != cpu) : (f == 2) ? (t == cpu) : 1'b1;
                if (hit) model[d[3:0]][t][cpu] = 1'b1;
            end
        end
        for (int n = 0; n < 16; n++) begin
            logic [7:0] v;
            logic clr_hit;
            logic set_hit;
            if (word) begin
                clr_hit = (a[1:0] == 2'b00) && (int'(a[11:2]) == (12'hF10 + n) / 4);
                set_hit = (a[1:0] == 2'b00) && (int'(a[11:2]) == (12'hF20 + n) / 4);
                v = d[8*(n%4) +: 8];
            end else begin
                clr_hit = (int'(a) == 12'hF10 + n);
                set_hit = (int'(a) == 12'hF20 + n);
                v = d[7:0];
            end
            if (clr_hit) model[n][cpu] = model[n][cpu] & ~v[NC-1:0];
            if (set_hit) model[n][cpu] = model[n][cpu] | v[NC-1:0];
        end
    endtask

    task automatic bus_write(input logic word, input logic [11:0] a,
                             input logic [31:0] d, input int cpu);
        @(negedge clk);
        wr_en = 1'b1; wr_word = word; wr_addr = a; wr_data = d; wr_cpu = CW'(cpu);
        @(negedge clk);
        wr_en = 1'b0;
        model_write(word, a, d, cpu);
    endtask

    task automatic do_ack(input int cpu, input int id, input string req);
        int exp;
        int s;
        s = low_src(model[id][cpu]);
        exp = 1023;
        if (s >= 0) begin
            exp = id | (s << 10);
            model[id][cpu][s] = 1'b0;
        end
        @(negedge clk);
        ack_req = 1'b1; ack_cpu = CW'(cpu); ack_id = 4'(id);
        @(negedge clk);
        ack_req = 1'b0;
        chk(req, int'(ack_rsp_valid), 1);
        chk(req, int'(ack_rsp), exp);
    endtask

    // compare the whole bitmap array and pending vector with the model
    task automatic check_state(input string req);
        for (int s = 0; s < 16; s++) begin
            for (int t = 0; t < NC; t++) begin
                rd_cpu = CW'(t);
                rd_addr = ((s + t) % 2 == 1) ? 12'(12'hF20 + s) : 12'(12'hF10 + s);
                #1;
                chk(req, int'(rd_data), int'(model[s][t]));
                chk("R4", int'(sgi_pend[t*16+s]), int'(model[s][t] != '0));
            end
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin : stim
        for (int s = 0; s < 16; s++)
            for (int t = 0; t < NC; t++) model[s][t] = '0;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_state("R1");
        chk("R1", int'(ack_rsp_valid), 0);

        // R2: every writer with every filter, IDs shared to stack sources
        for (int w = 0; w < NC; w++) begin
            for (int f = 0; f < 4; f++) begin
                logic [7:0] lst;
                int id;
                lst = 8'h5A ^ 8'(w * 16 + f * 3);
                id = (f * 3) % 16;
                bus_write(1'b1, 12'hF00, {6'd0, 2'(f), lst, 6'd0, 10'(id)}, w);
                check_state("R2");
            end
        end
        bus_write(1'b1, 12'hF00, {6'd0, 2'd3, 8'h00, 6'd0, 10'd15}, 3);
        check_state("R2");

        // R7, R5, R6: drain every bitmap in source order, then one empty ack
        for (int t = 0; t < NC; t++) begin
            for (int s = 0; s < 16; s++) begin
                while (model[s][t] != '0) do_ack(t, s, "R7");
                do_ack(t, s, "R6");
            end
        end
        check_state("R6");

        // R3: byte trigger, out-of-range ID, empty target set
        bus_write(1'b0, 12'hF00, 32'h0300_0001, 1);
        bus_write(1'b1, 12'hF00, {6'd0, 2'd3, 8'h00, 6'd0, 10'd20}, 2);
        bus_write(1'b1, 12'hF00, {6'd0, 2'd0, 8'hF0, 6'd0, 10'd5}, 0);
        check_state("R3");

        // R9: byte and word-lane sets, upper bits dropped
        bus_write(1'b0, 12'hF23, 32'h0000_000B, 1);
        bus_write(1'b1, 12'hF24, 32'hF00C_0301, 2);
        check_state("R9");

        // R8: byte and word-lane clears
        bus_write(1'b0, 12'hF13, 32'h0000_0002, 1);
        bus_write(1'b1, 12'hF14, 32'h0000_0201, 2);
        check_state("R8");

        // R10: address outside both banks reads zero
        rd_addr = 12'h100; rd_cpu = 2'd1;
        #1;
        chk("R10", int'(rd_data), 0);
        rd_addr = 12'hF03; rd_cpu = 2'd1;
        #1;
        chk("R10", int'(rd_data), 0);

        // R11: generic pending registers leave SGI state alone
        bus_write(1'b1, 12'h200, 32'hFFFF_FFFF, 0);
        bus_write(1'b1, 12'h280, 32'hFFFF_FFFF, 1);
        bus_write(1'b0, 12'h201, 32'h0000_00FF, 2);
        bus_write(1'b0, 12'h281, 32'h0000_00FF, 1);
        check_state("R11");

        // R12: set and acknowledge on the same bitmap in one cycle
        begin
            int s;
            int exp;
            s = low_src(model[3][1]);
            exp = 3 | (s << 10);
            @(negedge clk);
            wr_en = 1'b1; wr_word = 1'b0; wr_addr = 12'hF23; wr_data = 32'(1 << s); wr_cpu = 2'd1;
            ack_req = 1'b1; ack_cpu = 2'd1; ack_id = 4'd3;
            @(negedge clk);
            wr_en = 1'b0; ack_req = 1'b0;
            chk("R12", int'(ack_rsp), exp);
            check_state("R12");
        end
        do_ack(1, 3, "R12");
        do_ack(1, 3, "R7");
        do_ack(1, 3, "R6");
        check_state("R7");

        report();
    end

endmodule